// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Time-Out

The block watches for software that stops running. An 18-bit counter advances on each pulse of a watchdog tick input while the watchdog is enabled. When the counter crosses a selectable power-of-two interval, a sticky interrupt flag is raised. If software does not restart the counter within a fixed delay after that flag rises, the block issues a one-cycle system reset request. The reset request is gated by a reset-enable bit.

All configuration and status live in one 32-bit control word, reached over a plain register bus with an address, a write strobe, write data and combinational read data. The enable, the interval, the counter-restart command, the reset, interrupt and wake-up enables and the debug override are write-protected. Writes to those fields land only while the unlock input is high. The three status flags (interrupt, reset and wake-up) are sticky and are cleared by writing 1 to them. A wake-up request is raised when the interrupt path is live, wake-up is enabled, and the watchdog tick is known to come from the low-speed oscillator. A debug-halt input freezes the count unless the debug override bit is set.

Top module: `wdog_top`

## Requirements
- R1: After `rst_n` and `por_n` are both released, the control word reads 0 and `irq`, `wake_req` and `rst_req` are low.
- R2: Bits 0, 1, 4, 6, 7, 10:8 and 31 change only on a write made while `unlock` is 1. A write with `unlock` at 0 leaves them as they were.
- R3: A write of 1 to bit 0 while `unlock` is 1 sets the counter to zero on that edge. Bit 0 always reads 0.
- R4: The counter advances once per clock edge on which `wd_tick` is 1 and the enable (bit 7) is 1. Writing the enable to 0 sets the counter to zero.
- R5: With interval select s in bits 10:8, the interrupt flag (bit 3) sets on the 2^(4+2s)-th advancing tick counted from a zero counter. For s=7 the flag sets when the counter wraps past all-ones.
- R6: If reset enable (bit 1) is 1, `rst_req` pulses high for exactly one cycle on the 1024th advancing tick after the interrupt flag sets, unless the counter is restarted first. The reset flag (bit 2) sets on the same edge. With bit 1 at 0, no pulse occurs.
- R7: Bits 2, 3 and 5 are sticky. Writing 1 clears a flag with or without `unlock`. Writing 0 leaves it unchanged. A setting event on the same edge wins over a clear.
- R8: `irq` is 1 exactly when the interrupt enable (bit 6) and the interrupt flag are both 1.
- R9: `wake_req` is 1 only when bit 4, bit 6, the interrupt flag and `lsosc_sel` are all 1. While it is 1, the wake-up flag (bit 5) sets on the next edge.
- R10: While `dbg_halt` is 1 and bit 31 is 0, the counter holds its value. With bit 31 at 1, the counter keeps advancing during `dbg_halt`.
- R11: The reset flag is cleared by `por_n` only. Asserting `rst_n` alone clears every other bit but keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous watchdog reset |
| por_n | input | 1 | Active-low power-on reset, also clears the reset flag |
| wd_tick | input | 1 | Watchdog count enable, one pulse per watchdog clock period |
| reg_addr | input | 4 | Register address; the control word sits at 0 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| unlock | input | 1 | Opens the protected fields for writing |
| dbg_halt | input | 1 | Debugger holds the processor |
| lsosc_sel | input | 1 | Watchdog tick is derived from the low-speed oscillator |
| irq | output | 1 | Time-out interrupt |
| wake_req | output | 1 | Wake-up request to the power controller |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `por_n` is never low while `rst_n` is high, so the reset flag and the rest of the state reset together at power-up. They also assume `reg_addr` and `reg_wr` are stable across each clock edge. The stimulus asserts both resets together, then releases them together. It later pulses `rst_n` alone, and it changes bus inputs only a short time after a rising edge. No interface here carries a stream, so every pin is plain level or pulse signalling without back-pressure.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 3;
  localparam int B_CLR    = 0;
  localparam int B_RSTEN  = 1;
  localparam int B_RFLAG  = 2;
  localparam int B_IFLAG  = 3;
  localparam int B_WKE    = 4;
  localparam int B_WFLAG  = 5;
  localparam int B_IE     = 6;
  localparam int B_EN     = 7;
  localparam int B_SEL_LO = 8;
  localparam int B_DBGRUN = 31;

  typedef struct packed {
    logic             dbg_run;
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             ie;
    logic             wke;
    logic             rst_en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.dbg_run = w[B_DBGRUN];
    c.sel     = w[B_SEL_LO +: SEL_W];
    c.en      = w[B_EN];
    c.ie      = w[B_IE];
    c.wke     = w[B_WKE];
    c.rst_en  = w[B_RSTEN];
    return c;
  endfunction
endpackage

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 18,
  parameter int EXP_BASE    = 4,
  parameter int EXP_STEP    = 2,
  parameter int DELAY_TICKS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             clr,
  input  logic             freeze,
  input  logic             rst_en,
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic             fire,
  output logic             rst_pulse
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int DLY_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic [DLY_W-1:0] dcnt;
  logic             armed;
  logic             step;
  logic [NSEL-1:0]  wrap_at;

  assign step = en && tick && !freeze;

  for (genvar s = 0; s < NSEL; s++) begin : g_interval
    localparam int E_RAW = EXP_BASE + EXP_STEP * s;
    localparam int E     = (E_RAW > CNT_W) ? CNT_W : ((E_RAW < 1) ? 1 : E_RAW);
    assign wrap_at[s] = &cnt[E-1:0];
  end

  assign hit  = step && !clr && wrap_at[sel];
  assign fire = armed && step && !clr && (dcnt == DLY_LAST) && rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      dcnt      <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= fire;
      if (!en || clr) begin
        armed <= 1'b0;
        dcnt  <= '0;
      end else if (armed && step) begin
        if (dcnt == DLY_LAST) begin
          armed <= 1'b0;
          dcnt  <= '0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end else if (hit) begin
        armed <= 1'b1;
        dcnt  <= '0;
      end
    end
  end

  // R4: a disabled watchdog holds a zero count
  p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  // R4: no tick, no advance
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !tick) |=> $stable(cnt));

  // R10: debug halt without override freezes the count
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && freeze) |=> $stable(cnt));

  // R6: reset request is a single-cycle pulse
  p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              unlock,
  input  logic              hit,
  input  logic              rst_evt,
  input  logic              wake_evt,
  output ctrl_t             ctrl,
  output logic              clr_pulse,
  output logic              iflag,
  output logic              rflag,
  output logic              wflag,
  output logic [REG_W-1:0]  reg_rdata
);
  logic wr_hit, wr_prot;
  logic unused_wbits;

  assign wr_hit       = reg_wr && (reg_addr == '0);
  assign wr_prot      = wr_hit && unlock;
  assign clr_pulse    = wr_prot && reg_wdata[B_CLR];
  assign unused_wbits = ^reg_wdata[B_DBGRUN-1:B_SEL_LO+SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_prot) ctrl <= ctrl_from_word(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iflag <= 1'b0;
      wflag <= 1'b0;
    end else begin
      iflag <= hit      || (iflag && !(wr_hit && reg_wdata[B_IFLAG]));
      wflag <= wake_evt || (wflag && !(wr_hit && reg_wdata[B_WFLAG]));
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rflag <= 1'b0;
    else        rflag <= rst_evt || (rflag && !(wr_hit && reg_wdata[B_RFLAG]));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) begin
      reg_rdata[B_RSTEN]              = ctrl.rst_en;
      reg_rdata[B_RFLAG]              = rflag;
      reg_rdata[B_IFLAG]              = iflag;
      reg_rdata[B_WKE]                = ctrl.wke;
      reg_rdata[B_WFLAG]              = wflag;
      reg_rdata[B_IE]                 = ctrl.ie;
      reg_rdata[B_EN]                 = ctrl.en;
      reg_rdata[B_SEL_LO +: SEL_W]    = ctrl.sel;
      reg_rdata[B_DBGRUN]             = ctrl.dbg_run;
    end
  end

  // R2: locked writes leave protected fields untouched
  p_protect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !unlock) |=> $stable(ctrl));

  // R7: interrupt flag stays set until written with 1
  p_iflag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iflag && !(wr_hit && reg_wdata[B_IFLAG])) |=> iflag);

  // R6: reset event records the reset flag
  p_rflag_on_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> rflag);
endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CNT_W       = 18,
  parameter int EXP_BASE    = 4,
  parameter int EXP_STEP    = 2,
  parameter int DELAY_TICKS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wd_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              unlock,
  input  logic              dbg_halt,
  input  logic              lsosc_sel,
  output logic              irq,
  output logic              wake_req,
  output logic              rst_req
);
  ctrl_t ctrl;
  logic  clr_pulse, hit, fire, iflag, rflag, wflag, freeze;

  assign freeze   = dbg_halt && !ctrl.dbg_run;
  assign irq      = ctrl.ie && iflag;
  assign wake_req = irq && ctrl.wke && lsosc_sel;

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .unlock    (unlock),
    .hit       (hit),
    .rst_evt   (fire),
    .wake_evt  (wake_req),
    .ctrl      (ctrl),
    .clr_pulse (clr_pulse),
    .iflag     (iflag),
    .rflag     (rflag),
    .wflag     (wflag),
    .reg_rdata (reg_rdata)
  );

  wdog_count #(
    .CNT_W       (CNT_W),
    .EXP_BASE    (EXP_BASE),
    .EXP_STEP    (EXP_STEP),
    .DELAY_TICKS (DELAY_TICKS)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (wd_tick),
    .en        (ctrl.en),
    .clr       (clr_pulse),
    .freeze    (freeze),
    .rst_en    (ctrl.rst_en),
    .sel       (ctrl.sel),
    .hit       (hit),
    .fire      (fire),
    .rst_pulse (rst_req)
  );

  // R9: a wake-up request records the wake-up flag
  p_wake_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> wflag);

  // R6: the reset pulse coincides with a set reset flag
  p_pulse_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rflag);
endmodule

// File: tb/wdog_top_test.sv
`timescale 1ns/1ps
module wdog_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        wd_tick = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        unlock = 1'b0, dbg_halt = 1'b0, lsosc_sel = 1'b0;
  logic        irq, wake_req, rst_req;

  int checks = 0, failures = 0;
  int cyc = 0, n_pulse = 0, pulse_cyc = -1;
  int c0;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 wake, 3 rst_req, 4 pulse count, 5 pulse cycle
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];
  event  sample_ev;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_req) begin n_pulse <= n_pulse + 1; pulse_cyc <= cyc; end

  wdog_top uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wd_tick(wd_tick),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .unlock(unlock), .dbg_halt(dbg_halt), .lsosc_sel(lsosc_sel),
    .irq(irq), .wake_req(wake_req), .rst_req(rst_req)
  );

  // monitor: pops expected items and compares with the pins
  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {31'b0, irq};
        2: act = {31'b0, wake_req};
        3: act = {31'b0, rst_req};
        4: act = n_pulse;
        default: act = pulse_cyc;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    ->sample_ev;
    #0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [31:0] d, input logic unl);
    unlock = unl; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #2;
    reg_wr = 1'b0; unlock = 1'b0;
  endtask

  task automatic finish_up;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    adv(3);
    rst_n = 1'b1; por_n = 1'b1;
    adv(1);
    expect_item(0, 32'h0, "R1 reset word");
    expect_item(1, 0, "R1 irq");
    expect_item(2, 0, "R1 wake");
    expect_item(3, 0, "R1 rst_req");

    wr(32'h8000_07D3, 1'b0);
    expect_item(0, 32'h0, "R2 locked write ignored");
    wr(32'h0000_00C2, 1'b1);
    c0 = cyc;
    expect_item(0, 32'h0000_00C2, "R2 unlocked write");
    adv(15);
    expect_item(0, 32'h0000_00C2, "R5 sel0 before 16 ticks");
    adv(1);
    expect_item(0, 32'h0000_00CA, "R5 sel0 flag at 16 ticks");
    expect_item(1, 1, "R8 irq with ie and flag");
    wr(32'h0, 1'b0);
    expect_item(0, 32'h0000_00CA, "R7 write zero keeps flag");

    adv(1022);
    expect_item(4, 0, "R6 no pulse before 1024 ticks");
    adv(1);
    expect_item(3, 1, "R6 pulse high");
    expect_item(0, 32'h0000_00CE, "R6 reset flag set");
    adv(1);
    expect_item(3, 0, "R6 pulse one cycle");
    expect_item(4, 1, "R6 pulse count");
    expect_item(5, c0 + 1040, "R6 pulse timing");

    rst_n = 1'b0;
    adv(2);
    rst_n = 1'b1;
    adv(1);
    expect_item(0, 32'h0000_0004, "R11 reset flag kept over rst_n");
    expect_item(1, 0, "R1 irq after rst_n");
    wr(32'h0000_0004, 1'b0);
    expect_item(0, 32'h0, "R7 reset flag write-one clear");

    wr(32'h0000_00C0, 1'b1);
    adv(10);
    wr(32'h0000_00C1, 1'b1);
    expect_item(0, 32'h0000_00C0, "R3 clear bit reads zero");
    adv(15);
    expect_item(0, 32'h0000_00C0, "R3 count restarted");
    adv(1);
    expect_item(0, 32'h0000_00C8, "R3 flag 16 ticks after clear");
    adv(1100);
    expect_item(4, 1, "R6 no pulse with reset disabled");

    lsosc_sel = 1'b0;
    wr(32'h0000_00D0, 1'b1);
    expect_item(2, 0, "R9 no wake without low-speed source");
    expect_item(0, 32'h0000_00D8, "R9 wake flag clear");
    lsosc_sel = 1'b1;
    #1;
    expect_item(2, 1, "R9 wake request");
    adv(1);
    expect_item(0, 32'h0000_00F8, "R9 wake flag set");
    wr(32'h0000_0090, 1'b1);
    expect_item(1, 0, "R8 irq off with ie 0");
    expect_item(2, 0, "R9 wake off with ie 0");
    lsosc_sel = 1'b0;
    wr(32'h0, 1'b1);
    expect_item(0, 32'h0000_0028, "R7 flags survive disable");
    wr(32'h0000_0028, 1'b0);
    expect_item(0, 32'h0, "R7 both flags cleared");

    wr(32'h0000_0180, 1'b1);
    adv(63);
    expect_item(0, 32'h0000_0180, "R5 sel1 before 64 ticks");
    adv(1);
    expect_item(0, 32'h0000_0188, "R5 sel1 at 64 ticks");

    wr(32'h0, 1'b1);
    wr(32'h0000_0008, 1'b0);
    wd_tick = 1'b0;
    wr(32'h0000_0080, 1'b1);
    adv(40);
    expect_item(0, 32'h0000_0080, "R4 no count without tick");
    wd_tick = 1'b1;
    adv(15);
    expect_item(0, 32'h0000_0080, "R4 counting 15 ticks");
    adv(1);
    expect_item(0, 32'h0000_0088, "R4 counting 16 ticks");

    wr(32'h0, 1'b1);
    wr(32'h0000_0008, 1'b0);
    dbg_halt = 1'b1;
    wr(32'h0000_0080, 1'b1);
    adv(40);
    expect_item(0, 32'h0000_0080, "R10 frozen in debug");
    wr(32'h8000_0080, 1'b1);
    adv(15);
    expect_item(0, 32'h8000_0080, "R10 override 15 ticks");
    adv(1);
    expect_item(0, 32'h8000_0088, "R10 override 16 ticks");
    dbg_halt = 1'b0;

    wr(32'h0, 1'b1);
    wr(32'h0000_0008, 1'b0);
    wr(32'h0000_0080, 1'b1);
    adv(10);
    wr(32'h0, 1'b1);
    wr(32'h0000_0080, 1'b1);
    adv(15);
    expect_item(0, 32'h0000_0080, "R4 disable zeroed count");
    adv(1);
    expect_item(0, 32'h0000_0088, "R4 fresh count after re-enable");

    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
    end
    finish_up();
  end
endmodule